// File: doc/BRIEF.md
# NAND Address Cycle Generator

This block turns a column offset and a page number into the address bytes of one NAND flash operation and puts them on an 8-bit flash bus. It sends one byte per address-latch cycle. A controller pulses `start` with the operation class and the device geometry. The geometry is small or large page, 8- or 16-bit bus, and a capacity tier. The block then works out how many address bytes the device expects and how the column and page are packed into them. It sends the bytes least significant first while the downstream `ready` is high.

Operands are captured when `start` is accepted. While a sequence is in progress, the block ignores new `start` pulses and operand changes. One cycle after the final byte is accepted, `done` pulses high for one cycle. Command cycles, data transfer and strobe timing are handled elsewhere.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `ale`, `byte_valid` and `done` are low and `addr_byte` reads 0x00.
- R2: Read/program on a small-page device (`op_cls`=0, or the reserved code 3) sends the column low byte first, then page bits [7:0], [15:8] and [23:16], cut to the byte count of R5.
- R3: Read/program on a large-page device sends the column low byte first, then a byte carrying column bits [11:8] in its low nibble with the upper nibble zero, then page bits [7:0], [15:8] and [23:16], cut to the byte count of R5.
- R4: Erase (`op_cls`=1) sends no column byte, only page bytes from bits [7:0] upward.
- R5: The byte count depends on the capacity tier `cap_tier` (0, 1 or 2).
  - Small-page read/program sends 2, 3 or 4 bytes.
  - Large-page read/program sends 3, 4 or 5 bytes.
  - Erase sends 1, 2 or 3 bytes on either page size.
- R6: With `bus16`=1, read/program uses the column shifted right by one bit. ID reads use the column unchanged.
- R7: An ID read (`op_cls`=2) sends exactly one byte, the column low byte.
- R8: While `ale` is high, `byte_valid` equals `ready`.
  - A byte advances only on a cycle where `ready` is high.
  - While `ready` is low, `addr_byte` and `ale` hold.
- R9: `done` is high for exactly one cycle: the cycle after the final byte is accepted. `ale` is low in that cycle.
- R10: While a sequence runs, a `start` pulse and any change of `op_cls`, geometry, `col` or `page` have no effect on the bytes sent.
- R11: `cap_tier`=3 behaves exactly as `cap_tier`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence; accepted only when idle |
| op_cls | input | 2 | 0 read/program, 1 erase, 2 ID read, 3 read/program |
| large_page | input | 1 | 1 = large-page device packing |
| bus16 | input | 1 | 1 = 16-bit flash bus (word column) |
| cap_tier | input | 2 | Capacity tier selecting the address byte count |
| col | input | COL_W | Column offset in bytes |
| page | input | PAGE_W | Page number |
| ready | input | 1 | Downstream accepts the current byte |
| addr_byte | output | 8 | Address byte on the flash bus |
| ale | output | 1 | Address-latch-enable qualifier, high while sending |
| byte_valid | output | 1 | Pulses for each byte accepted |
| done | output | 1 | One-cycle pulse after the last byte |

## Verification
The assertions take for granted that `ready` and `start` are known after reset. They do not assume that `ready` ever rises, so a stall of any length is legal.

The bench drives `ready` with both steady-high and random patterns. Random patterns always make progress. During a running sequence it deliberately scrambles operands and re-pulses `start`, so the latching rule is tested rather than assumed. Each geometry, each operation class and the reserved tier and opcode values are covered by directed cases before a random sweep.

// File: rtl/nand_addr_pkg.sv
package nand_addr_pkg;

    localparam int MAX_ADDR_BYTES = 5;
    localparam int CNT_W          = $clog2(MAX_ADDR_BYTES + 1);
    localparam int COL_PAD_W      = 16;
    localparam int PAGE_PAD_W     = 32;
    localparam int PAGE_BYTES     = 3;

    typedef enum logic [1:0] {
        OPC_RW    = 2'd0,
        OPC_ERASE = 2'd1,
        OPC_ID    = 2'd2,
        OPC_RSVD  = 2'd3
    } op_cls_t;

    typedef enum logic [1:0] {
        TIER_SMALL = 2'd0,
        TIER_MID   = 2'd1,
        TIER_BIG   = 2'd2,
        TIER_XTRA  = 2'd3
    } cap_tier_t;

    typedef struct packed {
        logic      large_page;
        logic      bus16;
        cap_tier_t tier;
    } geom_t;

    typedef logic [MAX_ADDR_BYTES-1:0][7:0] byte_vec_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        byte_vec_t        bytes;
    } addr_job_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } seq_state_t;

    // Capacity rank 0..2; the spare tier code folds onto the biggest.
    function automatic logic [1:0] tier_rank(cap_tier_t t);
        return (t == TIER_XTRA) ? 2'd2 : 2'(t);
    endfunction

    // Number of address bytes for an operation on a given geometry.
    function automatic logic [CNT_W-1:0] addr_len(op_cls_t op, geom_t g);
        logic [CNT_W-1:0] r;
        r = CNT_W'(tier_rank(g.tier));
        case (op)
            OPC_ID:    return CNT_W'(1);
            OPC_ERASE: return r + CNT_W'(1);
            default:   return g.large_page ? r + CNT_W'(3) : r + CNT_W'(2);
        endcase
    endfunction

endpackage

// File: rtl/nand_addr_count.sv
module nand_addr_count
    import nand_addr_pkg::*;
(
    input  op_cls_t          op,
    input  geom_t            geom,
    output logic [CNT_W-1:0] cnt
);

    always_comb begin
        cnt = addr_len(op, geom);
    end

endmodule

// File: rtl/nand_addr_pack.sv
module nand_addr_pack
    import nand_addr_pkg::*;
#(
    parameter int COL_W  = 12,
    parameter int PAGE_W = 24
) (
    input  op_cls_t           op,
    input  geom_t             geom,
    input  logic [COL_W-1:0]  col,
    input  logic [PAGE_W-1:0] page,
    output byte_vec_t         bytes
);

    localparam int COL_HI_W = COL_W - 8;

    logic [COL_PAD_W-1:0]  col_w;
    logic [COL_PAD_W-1:0]  col_eff;
    logic [PAGE_PAD_W-1:0] page_w;
    logic [7:0]            page_b [PAGE_BYTES];
    logic [7:0]            col_hi;

    always_comb begin
        col_w  = COL_PAD_W'(col);
        page_w = PAGE_PAD_W'(page);
        // Word bus: column counts 16-bit words, except for ID reads.
        if (geom.bus16 && op != OPC_ID) begin
            col_eff = col_w >> 1;
        end else begin
            col_eff = col_w;
        end
    end

    // Column high byte keeps only bits above bit 7 up to the column width.
    generate
        if (COL_HI_W >= 8) begin : g_col_hi_full
            assign col_hi = col_eff[15:8];
        end else begin : g_col_hi_part
            assign col_hi = {{(8 - COL_HI_W){1'b0}}, col_eff[COL_W-1:8]};
        end
    endgenerate

    generate
        for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_page_byte
            assign page_b[k] = page_w[8*k +: 8];
        end
    endgenerate

    always_comb begin
        bytes = '0;
        case (op)
            OPC_ERASE: begin
                for (int i = 0; i < PAGE_BYTES; i++) begin
                    bytes[i] = page_b[i];
                end
            end
            OPC_ID: begin
                bytes[0] = col_w[7:0];
            end
            default: begin
                bytes[0] = col_eff[7:0];
                if (geom.large_page) begin
                    bytes[1] = col_hi;
                    for (int i = 0; i < PAGE_BYTES; i++) begin
                        bytes[i+2] = page_b[i];
                    end
                end else begin
                    for (int i = 0; i < PAGE_BYTES; i++) begin
                        bytes[i+1] = page_b[i];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/nand_addr_drive.sv
module nand_addr_drive
    import nand_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  addr_job_t  job,
    input  logic       ready,
    output logic [7:0] addr_byte,
    output logic       ale,
    output logic       byte_valid,
    output logic       done
);

    seq_state_t       state_q;
    addr_job_t        job_q;
    logic [CNT_W-1:0] idx_q;
    logic             last_byte;

    assign last_byte = (idx_q == job_q.cnt - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            job_q   <= '0;
            idx_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        job_q   <= job;
                        idx_q   <= '0;
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (ready) begin
                        if (last_byte) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                        end else begin
                            idx_q <= idx_q + CNT_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ale        = (state_q == ST_SEND);
        byte_valid = ale && ready;
        addr_byte  = 8'h00;
        for (int i = 0; i < MAX_ADDR_BYTES; i++) begin
            if (ale && idx_q == CNT_W'(i)) begin
                addr_byte = job_q.bytes[i];
            end
        end
    end

    // R8
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (ale && !ready) |=> (ale && $stable(addr_byte)));

    // R8
    valid_needs_ale_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> ale);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> (done && $past(byte_valid)));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !ale);

    // R1
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ale |-> (addr_byte == 8'h00 && !byte_valid));

endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
    import nand_addr_pkg::*;
#(
    parameter int COL_W  = 12,
    parameter int PAGE_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op_cls,
    input  logic              large_page,
    input  logic              bus16,
    input  logic [1:0]        cap_tier,
    input  logic [COL_W-1:0]  col,
    input  logic [PAGE_W-1:0] page,
    input  logic              ready,
    output logic [7:0]        addr_byte,
    output logic              ale,
    output logic              byte_valid,
    output logic              done
);

    op_cls_t          op;
    geom_t            geom;
    logic [CNT_W-1:0] cnt;
    byte_vec_t        bytes;
    addr_job_t        job;

    assign op              = op_cls_t'(op_cls);
    assign geom.large_page = large_page;
    assign geom.bus16      = bus16;
    assign geom.tier       = cap_tier_t'(cap_tier);

    nand_addr_count u_count (
        .op   (op),
        .geom (geom),
        .cnt  (cnt)
    );

    nand_addr_pack #(
        .COL_W  (COL_W),
        .PAGE_W (PAGE_W)
    ) u_pack (
        .op    (op),
        .geom  (geom),
        .col   (col),
        .page  (page),
        .bytes (bytes)
    );

    assign job.cnt   = cnt;
    assign job.bytes = bytes;

    nand_addr_drive u_drive (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .job        (job),
        .ready      (ready),
        .addr_byte  (addr_byte),
        .ale        (ale),
        .byte_valid (byte_valid),
        .done       (done)
    );

    // R5
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (cnt >= CNT_W'(1) && cnt <= CNT_W'(MAX_ADDR_BYTES)));

    // R10
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (ale && start && !ready) |=> (ale && $stable(addr_byte)));

endmodule

// File: tb/nand_addr_seq_bench.sv
module nand_addr_seq_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  op_cls;
    logic        large_page;
    logic        bus16;
    logic [1:0]  cap_tier;
    logic [11:0] col;
    logic [23:0] page;
    logic        ready;
    logic [7:0]  addr_byte;
    logic        ale;
    logic        byte_valid;
    logic        done;

    always #5 clk = ~clk;

    nand_addr_seq u_nand_addr_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op_cls     (op_cls),
        .large_page (large_page),
        .bus16      (bus16),
        .cap_tier   (cap_tier),
        .col        (col),
        .page       (page),
        .ready      (ready),
        .addr_byte  (addr_byte),
        .ale        (ale),
        .byte_valid (byte_valid),
        .done       (done)
    );

    int         n_checks = 0;
    int         n_errs   = 0;
    int         cycles   = 0;
    string      tag      = "R1";
    logic [7:0] exp_q[$];
    bit         m_busy   = 0;
    bit         m_done   = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Reference expectation built from the requirement text.
    function automatic void load_exp(logic [1:0] op, logic lg, logic b16,
                                     logic [1:0] tr, int c, int p);
        int t;
        int c2;
        t = (tr == 2'd3) ? 2 : int'(tr);            // R11
        if (op == 2'd2) begin                        // R7
            exp_q.push_back(8'(c & 'hff));
        end else if (op == 2'd1) begin               // R4
            for (int i = 0; i < t + 1; i++) exp_q.push_back(8'((p >> (8*i)) & 'hff));
        end else begin                               // R2 R3 R6
            c2 = b16 ? (c >> 1) : c;
            exp_q.push_back(8'(c2 & 'hff));
            if (lg) exp_q.push_back(8'((c2 >> 8) & 'hf));
            for (int i = 0; i < t + 1; i++) exp_q.push_back(8'((p >> (8*i)) & 'hff));
        end
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    // Compare and advance the model away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            summary();
            $finish;
        end
        if (rst) begin
            m_busy = 0;
            m_done = 0;
            exp_q.delete();
        end else begin
            chk(tag, "ale", int'(ale), int'(m_busy));
            chk(tag, "done", int'(done), int'(m_done));
            chk(tag, "byte_valid", int'(byte_valid), int'(m_busy && ready));
            chk(tag, "addr_byte", int'(addr_byte), m_busy ? int'(exp_q[0]) : 0);
            m_done = 0;
            if (m_busy) begin
                if (ready) begin
                    void'(exp_q.pop_front());
                    if (exp_q.size() == 0) begin
                        m_busy = 0;
                        m_done = 1;
                    end
                end
            end else if (start) begin
                load_exp(op_cls, large_page, bus16, cap_tier, int'(col), int'(page));
                m_busy = 1;
            end
        end
    end

    // rmode: 0 ready held high, 1 random ready. noise: scramble operands and re-start mid-run (R10).
    task automatic run_op(string t, logic [1:0] op, logic lg, logic b16, logic [1:0] tr,
                          logic [11:0] c, logic [23:0] p, int rmode, bit noise);
        int guard;
        tag        = t;
        op_cls     = op;
        large_page = lg;
        bus16      = b16;
        cap_tier   = tr;
        col        = c;
        page       = p;
        start      = 1'b1;
        ready      = (rmode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
        @(posedge clk); #1;
        start = 1'b0;
        guard = 0;
        while (!done && guard < 200) begin
            if (rmode != 0) ready = 1'($urandom_range(0, 1));
            if (noise) begin
                start      = 1'($urandom_range(0, 1));
                op_cls     = 2'($urandom);
                large_page = 1'($urandom);
                bus16      = 1'($urandom);
                cap_tier   = 2'($urandom);
                col        = 12'($urandom);
                page       = 24'($urandom);
            end
            @(posedge clk); #1;
            guard++;
        end
        start = 1'b0;
        ready = 1'b1;
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; op_cls = '0; large_page = 1'b0; bus16 = 1'b0;
        cap_tier = '0; col = '0; page = '0; ready = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "reset ale", int'(ale), 0);
        chk("R1", "reset done", int'(done), 0);
        chk("R1", "reset byte_valid", int'(byte_valid), 0);
        chk("R1", "reset addr_byte", int'(addr_byte), 0);
        rst = 1'b0;
        @(posedge clk); #1;

        // R2 small-page read/program, each tier; R5 counts
        for (int tr = 0; tr < 3; tr++) run_op("R2", 2'd0, 1'b0, 1'b0, 2'(tr), 12'h0A5, 24'h123456, 0, 0);
        run_op("R2", 2'd3, 1'b0, 1'b0, 2'd2, 12'h03C, 24'hFEDCBA, 0, 0);
        // R3 large-page read/program; R5 counts
        for (int tr = 0; tr < 3; tr++) run_op("R3", 2'd0, 1'b1, 1'b0, 2'(tr), 12'hABC, 24'h789ABC, 0, 0);
        // R4 erase on both geometries; R5 counts
        for (int tr = 0; tr < 3; tr++) begin
            run_op("R4", 2'd1, 1'b0, 1'b0, 2'(tr), 12'hFFF, 24'hC0FFEE, 0, 0);
            run_op("R4", 2'd1, 1'b1, 1'b1, 2'(tr), 12'h555, 24'h0A0B0C, 0, 0);
        end
        // R6 word bus halves the column
        run_op("R6", 2'd0, 1'b1, 1'b1, 2'd1, 12'h801, 24'h000102, 0, 0);
        run_op("R6", 2'd0, 1'b0, 1'b1, 2'd0, 12'h0FF, 24'h0000AA, 0, 0);
        // R7 ID read, byte column even on word bus
        run_op("R7", 2'd2, 1'b1, 1'b1, 2'd2, 12'h090, 24'h123456, 0, 0);
        run_op("R7", 2'd2, 1'b0, 1'b0, 2'd0, 12'h000, 24'hFFFFFF, 0, 0);
        // R11 spare tier equals biggest tier
        run_op("R11", 2'd0, 1'b1, 1'b0, 2'd3, 12'h123, 24'hABCDEF, 0, 0);
        run_op("R11", 2'd1, 1'b0, 1'b0, 2'd3, 12'h123, 24'hABCDEF, 0, 0);
        // R8 stalls from a random ready
        for (int i = 0; i < 20; i++)
            run_op("R8", 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                   12'($urandom), 24'($urandom), 1, 0);
        // R10 start and operand changes while running
        for (int i = 0; i < 20; i++)
            run_op("R10", 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                   12'($urandom), 24'($urandom), 1, 1);
        // R9 back-to-back sweep: done then immediate restart
        for (int i = 0; i < 200; i++)
            run_op("R9", 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                   12'($urandom), 24'($urandom), int'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

        repeat (4) @(posedge clk);
        #1;
        summary();
        $finish;
    end

endmodule